// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block plays out the power-up command program of a DDR2 memory from a table of sixteen slots that firmware fills in. Each slot holds one 32-bit word with an enable flag, a post-command hold count, a 3-bit command code, a bank address and a row/mode address. The whole JEDEC initialization order therefore comes from the table rather than from fixed logic. Firmware loads the slots through a valid/ready write port, raises the CKE request, and pulses `start`. The sequencer then walks the slots in index order. For every enabled slot it places exactly one command on a registered memory-command bus, then holds the bus deselected for the programmed number of cycles.

Write-port rules: `wr_ready` is high exactly when the block is idle. A word moves into slot `wr_slot` on a rising clock edge where `wr_valid` and `wr_ready` are both high. While a program is running the port refuses all transfers, and a sender that still needs to write must hold `wr_valid` until `wr_ready` returns. The bus carries no back-pressure.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` and `done` are 0, `mem_cke` is 0, and the bus is deselected (`mem_cs_n`, `mem_ras_n`, `mem_cas_n` and `mem_we_n` all 1, `mem_ba` and `mem_addr` 0). Reset also clears every slot to disabled, so a program started straight after reset issues no command.
- R2: `wr_ready` is 1 whenever `busy` is 0. A word with `wr_valid` high is stored into slot `wr_slot` at that edge.
- R3: Slot word fields are: bit 31 enable, bits 30:23 hold count, bits 21:19 command code, bits 18:16 bank, bits 14:0 address. On a command cycle `mem_cs_n` is 0, command bits 21, 20 and 19 appear on `mem_ras_n`, `mem_cas_n` and `mem_we_n`, and the bank and address fields appear unchanged. Bits 22 and 15 have no effect.
- R4: Slots are visited strictly from 0 to 15. Each enabled slot drives exactly one cycle with `mem_cs_n` low. Outside those cycles the bus is deselected.
- R5: An enabled slot with hold count N is followed by exactly N deselected cycles before the next slot is visited. With N = 0 the next slot issues on the very next cycle.
- R6: A slot with bit 31 clear issues nothing and takes one deselected cycle, whatever its other bits hold.
- R7: A `start` sampled high while idle makes `busy` high in the next cycle. That cycle is deselected, and slot 0 is visited in the cycle after it. A `start` sampled while busy has no effect on the running program.
- R8: While `busy` is 1, `wr_ready` is 0 and slot contents cannot change through the write port.
- R9: `busy` stays high through the last cycle produced by slot 15. In the next cycle `busy` is 0 and `done` is 1, for exactly one cycle.
- R10: `mem_cke` equals `cke_req` delayed by one clock.
- R11: A table holding NOP/80, precharge-all/3, EMR2/2, EMR3/2, EMR/2, MR with DLL reset/2, precharge-all/3, four refreshes/26, MR/2, EMR with OCD enter/2 and EMR with OCD exit/2, followed by two disabled slots, reproduces that command order and spacing. Codes used: NOP 7, precharge 2 (address bit 10 = all banks), refresh 1, mode set 0 (bank 0 MR, 1 EMR, 2 EMR2, 3 EMR3), write 4, read 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Slot write request |
| wr_ready | output | 1 | Slot write accepted this cycle (idle) |
| wr_slot | input | IDX_W (4) | Slot index written |
| wr_data | input | 32 | Slot word |
| start | input | 1 | Begin the program (sampled while idle) |
| cke_req | input | 1 | Requested clock-enable level |
| mem_cke | output | 1 | Registered clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address |
| mem_addr | output | 15 | Row / mode address |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default values: sixteen slots and an 8-bit hold count. With these values a single table can carry the full JEDEC power-up program and still leave the two trailing slots disabled. The largest hold of 255 can sit on the final slot, where it meets the completion logic. The bench also reaches the case where slot 15 issues with zero hold, which pins down exactly when `done` rises relative to the last command. The longest program is about four thousand cycles, so every slot index and every hold boundary can be driven directly.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // Slot word geometry; field placement is fixed because firmware encodes it
  localparam int SLOT_W  = 32;
  localparam int WAIT_W  = 8;
  localparam int CMD_W   = 3;
  localparam int BA_W    = 3;
  localparam int ADDR_W  = 15;

  localparam int EN_POS   = SLOT_W - 1;              // 31
  localparam int WAIT_LSB = EN_POS - WAIT_W;         // 23
  localparam int CMD_LSB  = WAIT_LSB - 1 - CMD_W;    // 19 (bit 22 reserved)
  localparam int BA_LSB   = CMD_LSB - BA_W;          // 16
  localparam int RSV_LO   = BA_LSB - 1;              // 15 reserved
  localparam int RSV_HI   = WAIT_LSB - 1;            // 22 reserved
  localparam int ADDR_LSB = 0;

  typedef struct packed {
    logic              en;
    logic [WAIT_W-1:0] hold;
    logic [CMD_W-1:0]  cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
  } slot_t;

  typedef struct packed {
    logic              cs_n;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
  } mem_cmd_t;

  localparam mem_cmd_t MEM_DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                        we_n: 1'b1, ba: '0, addr: '0};

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_HOLD,
    SQ_TAIL
  } seq_state_e;

endpackage

// File: rtl/ddr2_slot_decode.sv
module ddr2_slot_decode
  import ddr2_init_pkg::*;
(
  input  logic [SLOT_W-1:0] word,
  output slot_t             fields
);

  // reserved bits carry no meaning; folded away so they reach no state
  logic unused_rsv;
  assign unused_rsv = ^{word[RSV_HI], word[RSV_LO]};

  always_comb begin
    fields.en   = word[EN_POS];
    fields.hold = word[WAIT_LSB +: WAIT_W];
    fields.cmd  = word[CMD_LSB  +: CMD_W];
    fields.ba   = word[BA_LSB   +: BA_W];
    fields.addr = word[ADDR_LSB +: ADDR_W];
  end

endmodule

// File: rtl/ddr2_slot_bank.sv
module ddr2_slot_bank
  import ddr2_init_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  slot_t            wr_fields,
  input  logic [IDX_W-1:0] rd_idx,
  output slot_t            rd_fields
);

  slot_t slot_vec [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    slot_t q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        q <= wr_fields;
      end
    end
    assign slot_vec[g] = q;
  end

  assign rd_fields = slot_vec[rd_idx];

endmodule

// File: rtl/ddr2_seq_ctrl.sv
module ddr2_seq_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  slot_t            cur,
  output logic [IDX_W-1:0] slot_idx,
  output logic             issue,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);
  localparam logic [WAIT_W-1:0] HOLD_ONE = WAIT_W'(1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WAIT_W-1:0] hold_q, hold_d;
  logic              done_q, done_d;
  logic              slot_over;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    hold_d    = hold_q;
    done_d    = 1'b0;
    slot_over = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_ISSUE;
          idx_d   = '0;
        end
      end
      SQ_ISSUE: begin
        if (cur.en && (cur.hold != '0)) begin
          hold_d  = cur.hold;
          state_d = SQ_HOLD;
        end else begin
          slot_over = 1'b1;
        end
      end
      SQ_HOLD: begin
        if (hold_q == HOLD_ONE) slot_over = 1'b1;
        else                    hold_d    = hold_q - 1'b1;
      end
      SQ_TAIL: begin
        state_d = SQ_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
    if (slot_over) begin
      if (idx_q == LAST_IDX) begin
        state_d = SQ_TAIL;
      end else begin
        idx_d   = idx_q + 1'b1;
        state_d = SQ_ISSUE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      hold_q  <= hold_d;
      done_q  <= done_d;
    end
  end

  assign slot_idx = idx_q;
  assign issue    = (state_q == SQ_ISSUE) && cur.en;
  assign busy     = (state_q != SQ_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/ddr2_cmd_drive.sv
module ddr2_cmd_drive
  import ddr2_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [BA_W-1:0]   cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cke_req,
  output mem_cmd_t          bus_q,
  output logic              cke_q
);

  mem_cmd_t slot_cmd;

  always_comb begin
    slot_cmd.cs_n  = 1'b0;
    slot_cmd.ras_n = cmd_code[2];
    slot_cmd.cas_n = cmd_code[1];
    slot_cmd.we_n  = cmd_code[0];
    slot_cmd.ba    = cmd_ba;
    slot_cmd.addr  = cmd_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q <= MEM_DESELECT;
      cke_q <= 1'b0;
    end else begin
      bus_q <= issue ? slot_cmd : MEM_DESELECT;
      cke_q <= cke_req;
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter  int NUM_SLOTS = 16,
  localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [SLOT_W-1:0] wr_data,
  input  logic              start,
  input  logic              cke_req,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              done
);

  slot_t            wr_fields;
  slot_t            cur_slot;
  logic [IDX_W-1:0] cur_idx;
  logic             issue;
  logic             busy_i;
  logic             wr_en;
  mem_cmd_t         bus_q;

  assign wr_ready = ~busy_i;
  assign wr_en    = wr_valid & wr_ready;

  ddr2_slot_decode i_decode (
    .word   (wr_data),
    .fields (wr_fields)
  );

  ddr2_slot_bank #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_slot),
    .wr_fields (wr_fields),
    .rd_idx    (cur_idx),
    .rd_fields (cur_slot)
  );

  ddr2_seq_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cur      (cur_slot),
    .slot_idx (cur_idx),
    .issue    (issue),
    .busy     (busy_i),
    .done     (done)
  );

  ddr2_cmd_drive i_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .cmd_code (cur_slot.cmd),
    .cmd_ba   (cur_slot.ba),
    .cmd_addr (cur_slot.addr),
    .cke_req  (cke_req),
    .bus_q    (bus_q),
    .cke_q    (mem_cke)
  );

  assign mem_cs_n  = bus_q.cs_n;
  assign mem_ras_n = bus_q.ras_n;
  assign mem_cas_n = bus_q.cas_n;
  assign mem_we_n  = bus_q.we_n;
  assign mem_ba    = bus_q.ba;
  assign mem_addr  = bus_q.addr;
  assign busy      = busy_i;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk
  import ddr2_init_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cke_req,
  input logic              mem_cke,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic [BA_W-1:0]   mem_ba,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_fall_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_cmd_inside_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> busy);

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_ras_n && mem_cas_n && mem_we_n && (mem_ba == '0) && (mem_addr == '0)));

  assert_cke_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mem_cke == $past(cke_req)));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

bind ddr2_init_seq ddr2_init_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cke_req   (cke_req),
  .mem_cke   (mem_cke),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .mem_ba    (mem_ba),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_ddr2_init_seq.sv
module test_ddr2_init_seq;

  localparam int NS    = 16;
  localparam int MAXTR = 4400;

  logic        clk = 1'b0;
  logic        rst_n, wr_valid, start, cke_req;
  logic [3:0]  wr_slot;
  logic [31:0] wr_data;
  logic        wr_ready, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, busy, done;
  logic [2:0]  mem_ba;
  logic [14:0] mem_addr;

  always #5 clk = ~clk;

  ddr2_init_seq i_ddr2_init_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_slot(wr_slot), .wr_data(wr_data), .start(start), .cke_req(cke_req),
    .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
    .mem_addr(mem_addr), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model [NS];
  logic [21:0] exp_tr [MAXTR];
  int exp_len;

  wire [21:0] bus_now = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr};
  localparam logic [21:0] DESEL = {4'b1111, 18'd0};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_word(input int hold, input int cmd, input int ba,
                                            input int addr, input bit rsv);
    logic [31:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[30:23] = hold[7:0];
    w[22]    = rsv;
    w[21:19] = cmd[2:0];
    w[18:16] = ba[2:0];
    w[15]    = rsv;
    w[14:0]  = addr[14:0];
    return w;
  endfunction

  task automatic build_expected();
    exp_len = 0;
    for (int s = 0; s < NS; s++) begin
      if (model[s][31]) begin
        exp_tr[exp_len] = {1'b0, model[s][21:19], model[s][18:16], model[s][14:0]};
        exp_len++;
        for (int k = 0; k < int'(model[s][30:23]); k++) begin
          exp_tr[exp_len] = DESEL;
          exp_len++;
        end
      end else begin
        exp_tr[exp_len] = DESEL;
        exp_len++;
      end
    end
  endtask

  task automatic write_slot(input int idx, input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_slot  = idx[3:0];
    wr_data  = w;
    check(wr_ready == 1'b1, "R2", "ready while idle", 64'(wr_ready), 64'd1);
    @(negedge clk);
    wr_valid = 1'b0;
    model[idx] = w;
  endtask

  // runs the loaded table and compares every bus cycle against the model
  task automatic run_table(input string tag, input bit poke);
    build_expected();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && bus_now == DESEL, "R7", "first busy cycle",
          64'({busy, bus_now}), 64'({1'b1, DESEL}));
    if (poke) begin
      start    = 1'b1;
      wr_valid = 1'b1;
      wr_slot  = 4'd0;
      wr_data  = 32'hFFFF_FFFF;
      check(wr_ready == 1'b0, "R8", "ready while busy", 64'(wr_ready), 64'd0);
    end
    for (int i = 0; i < exp_len; i++) begin
      @(negedge clk);
      if (poke && i == 0) begin
        start    = 1'b0;
        wr_valid = 1'b0;
      end
      check({busy, bus_now} == {1'b1, exp_tr[i]}, tag, $sformatf("bus cycle %0d", i),
            64'({busy, bus_now}), 64'({1'b1, exp_tr[i]}));
    end
    @(negedge clk);
    check(!busy && done, "R9", "completion cycle", 64'({busy, done}), 64'b01);
    @(negedge clk);
    check(!busy && !done && bus_now == DESEL, "R9", "after completion",
          64'({busy, done, bus_now}), 64'({2'b00, DESEL}));
  endtask

  task automatic t_reset_state();
    check(!busy && !done && !mem_cke && bus_now == DESEL && wr_ready, "R1", "reset outputs",
          64'({busy, done, mem_cke, wr_ready, bus_now}), 64'({4'b0001, DESEL}));
  endtask

  task automatic t_cke();
    @(negedge clk);
    cke_req = 1'b1;
    check(mem_cke == 1'b0, "R10", "cke before edge", 64'(mem_cke), 64'd0);
    @(negedge clk);
    check(mem_cke == 1'b1, "R10", "cke rise", 64'(mem_cke), 64'd1);
    cke_req = 1'b0;
    @(negedge clk);
    check(mem_cke == 1'b0, "R10", "cke fall", 64'(mem_cke), 64'd0);
    cke_req = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_empty_after_reset();
    for (int s = 0; s < NS; s++) model[s] = '0;
    run_table("R1 R6 empty", 1'b0);
  endtask

  task automatic t_reference();
    write_slot(0,  slot_word(80, 7, 0, 0, 0));
    write_slot(1,  slot_word(3,  2, 0, 1024, 0));
    write_slot(2,  slot_word(2,  0, 2, 0, 0));
    write_slot(3,  slot_word(2,  0, 3, 0, 0));
    write_slot(4,  slot_word(2,  0, 1, 1028, 0));
    write_slot(5,  slot_word(2,  0, 0, 1346, 0));
    write_slot(6,  slot_word(3,  2, 0, 1024, 0));
    for (int s = 7; s < 11; s++) write_slot(s, slot_word(26, 1, 0, 0, 0));
    write_slot(11, slot_word(2,  0, 0, 1090, 0));
    write_slot(12, slot_word(2,  0, 1, 1920, 0));
    write_slot(13, slot_word(2,  0, 1, 1024, 0));
    write_slot(14, 32'h0);
    write_slot(15, 32'h0);
    run_table("R11 R4 R5 reference", 1'b0);
  endtask

  task automatic t_back_to_back();
    for (int s = 0; s < NS; s++) begin
      if (s % 4 == 1) write_slot(s, 32'h7FFF_FFFF);
      else write_slot(s, slot_word(0, (s % 2 == 1) ? 5 : 4, s % 8, (15'h1234 ^ (s * 37)), 1'b1));
    end
    run_table("R3 R5 R6 back-to-back", 1'b0);
  endtask

  task automatic t_max_hold();
    for (int s = 0; s < NS - 1; s++) write_slot(s, 32'h0);
    write_slot(NS - 1, slot_word(255, 1, 0, 0, 0));
    run_table("R5 R9 max hold", 1'b0);
  endtask

  task automatic t_busy_ignore();
    for (int s = 0; s < NS; s++)
      write_slot(s, slot_word(s % 3, 2, s % 4, (s[0] ? 1024 : 0), 1'b0));
    run_table("R7 R8 poked run", 1'b1);
    run_table("R8 contents kept", 1'b0);
  endtask

  task automatic t_reset_clears();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    cke_req = 1'b0;
    @(negedge clk);
    for (int s = 0; s < NS; s++) model[s] = '0;
    run_table("R1 cleared by reset", 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; start = 1'b0; cke_req = 1'b0;
    wr_slot = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_cke();
    t_empty_after_reset();
    t_reference();
    t_back_to_back();
    t_max_hold();
    t_busy_ignore();
    t_reset_clears();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule